// File: doc/BRIEF.md
# Condition Code Flag Generator

A combinational arithmetic unit that adds or subtracts two integer operands and produces, in the same cycle, the result together with the five condition flags an integer datapath needs: extend (X), negative (N), zero (Z), overflow (V) and carry (C). It handles byte, word and long operand sizes, and four operations: plain add, plain subtract, and the extended add and subtract that consume the incoming extend bit as a carry or borrow.

The extended forms exist for multi-word arithmetic. They fold the extend bit into the carry-in, and their zero flag can only be cleared, never set. A chain of extended operations therefore leaves Z set only if every word of the chain came out zero. The previous Z is supplied on its own input for this reason. For byte and word operations, the upper bits of the destination operand pass through unchanged into the result.

Top module: `ccgen_top`

## Requirements
- R1: For op_sel = 0 (add) and op_sel = 2 (extended add), the low bits of result at the selected size equal a + b, plus 1 when op_sel = 2 and x_in = 1, wrapped to that size. C (flags bit 0) is the unsigned carry out of that sum.
- R2: For op_sel = 1 (subtract) and op_sel = 3 (extended subtract), the low bits of result equal a − b, minus 1 when op_sel = 3 and x_in = 1, wrapped to the size. C is set when a < b unsigned, or when a ≤ b unsigned if the extra 1 is subtracted.
- R3: For the add forms, V (flags bit 1) is set exactly when a and b have the same sign at the selected size and the result's sign differs from it.
- R4: For the subtract forms, V is set exactly when the signed difference does not fit the selected size; this equals the top bit of (a XOR result) AND (a XOR b).
- R5: N (flags bit 3) is the top bit of the result at the selected size. For the plain forms, Z (flags bit 2) is set exactly when the result at that size is zero.
- R6: For the extended forms (op_sel 2 and 3), Z is the zero test of the result ANDed with z_prev. For the plain forms, z_prev has no effect.
- R7: X (flags bit 4) always equals C.
- R8: For the plain forms, x_in has no effect on result or flags.
- R9: size_sel = 0 selects 8 bits and size_sel = 1 selects 16 bits. In both cases the result bits above the size are copied from opnd_dst, and the upper bits of both operands do not affect the flags.
- R10: size_sel = 2 selects the full 32-bit width, and size_sel = 3 behaves exactly as size_sel = 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_dst | input | 32 | Destination operand a (the minuend for subtraction) |
| opnd_src | input | 32 | Source operand b (the subtrahend for subtraction) |
| op_sel | input | 2 | 0 add, 1 subtract, 2 extended add, 3 extended subtract |
| size_sel | input | 2 | 0 byte, 1 word, 2 or 3 long |
| x_in | input | 1 | Incoming extend flag |
| z_prev | input | 1 | Previous zero flag, used by the extended forms |
| result | output | 32 | Arithmetic result, upper bits merged from opnd_dst |
| flags | output | 5 | {X, N, Z, V, C}, bit 4 down to bit 0 |

## Verification
The bench builds the unit with the default DATA_W of 32, so the lanes are 8, 16 and 32 bits wide. With these widths, every sign and carry boundary of each lane (0x7F/0x80, 0xFF/0x00 and their word and long equivalents) can be hit with directed operands. The narrow byte lane is also dense enough that a few thousand random operand pairs cover its carry and overflow combinations many times over. A reference model in the bench uses 64-bit signed and unsigned arithmetic to predict the flags, so carry and overflow are judged by range rather than by bit tricks.

// File: rtl/ccgen_pkg.sv
package ccgen_pkg;

    typedef enum logic [1:0] {
        ALU_ADD  = 2'd0,
        ALU_SUB  = 2'd1,
        ALU_ADDX = 2'd2,
        ALU_SUBX = 2'd3
    } alu_op_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_WORD = 2'd1,
        SZ_LONG = 2'd2,
        SZ_ALT  = 2'd3
    } op_size_e;

    // flag bit positions inside the 5-bit flag vector
    localparam int FLG_C = 0;
    localparam int FLG_V = 1;
    localparam int FLG_Z = 2;
    localparam int FLG_N = 3;
    localparam int FLG_X = 4;
    localparam int FLG_W = 5;

    localparam int NUM_LANES = 3;

endpackage

// File: rtl/ccg_lane.sv
module ccg_lane #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    input  logic         cin,
    output logic [W-1:0] r,
    output logic         c,
    output logic         v,
    output logic         n,
    output logic         z
);

    logic [W:0] wide_d;

    always_comb begin
        if (sub) begin
            wide_d = {1'b0, a} - {1'b0, b} - {{W{1'b0}}, cin};
        end else begin
            wide_d = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
        end
        r = wide_d[W-1:0];
        c = wide_d[W];
        if (sub) begin
            v = (a[W-1] ^ r[W-1]) & (a[W-1] ^ b[W-1]);
        end else begin
            v = ~(a[W-1] ^ b[W-1]) & (a[W-1] ^ r[W-1]);
        end
        n = r[W-1];
        z = ~|r;
    end

    always_comb begin
        if (!sub) begin
            // R1
            add_carry_chk: assert (c == (cin ? (r <= b) : (r < b)))
                else $error("add carry mismatch");
            // R3
            if (a[W-1] != b[W-1]) begin
                add_ovf_chk: assert (!v)
                    else $error("add overflow with mixed signs");
            end
        end else begin
            // R2
            sub_carry_chk: assert (c == (cin ? (a <= b) : (a < b)))
                else $error("sub borrow mismatch");
        end
    end

endmodule

// File: rtl/ccg_merge.sv
module ccg_merge
    import ccgen_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0]                 a,
    input  logic [1:0]                        op_sel,
    input  logic [1:0]                        size_sel,
    input  logic                              z_prev,
    input  logic [NUM_LANES-1:0][DATA_W-1:0]  lane_r,
    input  logic [NUM_LANES-1:0]              lane_c,
    input  logic [NUM_LANES-1:0]              lane_v,
    input  logic [NUM_LANES-1:0]              lane_n,
    input  logic [NUM_LANES-1:0]              lane_z,
    output logic [DATA_W-1:0]                 result,
    output logic [FLG_W-1:0]                  flags
);

    localparam int BYTE_W = DATA_W / 4;
    localparam int WORD_W = DATA_W / 2;

    typedef struct packed {
        logic [DATA_W-1:0] res;
        logic [FLG_W-1:0]  flg;
    } merge_t;

    merge_t out_d;
    logic   ext_d;
    int     sel_d;

    always_comb begin
        ext_d = op_sel[1];
        case (op_size_e'(size_sel))
            SZ_BYTE: sel_d = 0;
            SZ_WORD: sel_d = 1;
            default: sel_d = 2;
        endcase

        out_d = '0;
        case (sel_d)
            0:       out_d.res = {a[DATA_W-1:BYTE_W], lane_r[0][BYTE_W-1:0]};
            1:       out_d.res = {a[DATA_W-1:WORD_W], lane_r[1][WORD_W-1:0]};
            default: out_d.res = lane_r[2];
        endcase

        out_d.flg[FLG_C] = lane_c[sel_d];
        out_d.flg[FLG_X] = lane_c[sel_d];
        out_d.flg[FLG_V] = lane_v[sel_d];
        out_d.flg[FLG_N] = lane_n[sel_d];
        out_d.flg[FLG_Z] = ext_d ? (lane_z[sel_d] & z_prev) : lane_z[sel_d];
    end

    assign result = out_d.res;
    assign flags  = out_d.flg;

    always_comb begin
        // R6
        if (ext_d && !z_prev) begin
            z_chain_chk: assert (!flags[FLG_Z])
                else $error("extended op set Z");
        end
        // R7
        x_mirror_chk: assert (flags[FLG_X] == flags[FLG_C])
            else $error("X differs from C");
        // R9
        if (sel_d == 0) begin
            byte_upper_chk: assert (result[DATA_W-1:BYTE_W] == a[DATA_W-1:BYTE_W])
                else $error("byte op altered upper bits");
        end
    end

endmodule

// File: rtl/ccgen_top.sv
module ccgen_top
    import ccgen_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] opnd_dst,
    input  logic [DATA_W-1:0] opnd_src,
    input  logic [1:0]        op_sel,
    input  logic [1:0]        size_sel,
    input  logic              x_in,
    input  logic              z_prev,
    output logic [DATA_W-1:0] result,
    output logic [4:0]        flags
);

    localparam int BYTE_W = DATA_W / 4;
    localparam int WORD_W = DATA_W / 2;

    logic                              sub_d;
    logic                              cin_d;
    logic [NUM_LANES-1:0][DATA_W-1:0]  lane_r;
    logic [NUM_LANES-1:0]              lane_c;
    logic [NUM_LANES-1:0]              lane_v;
    logic [NUM_LANES-1:0]              lane_n;
    logic [NUM_LANES-1:0]              lane_z;

    // plain forms ignore the extend bit entirely
    assign sub_d = op_sel[0];
    assign cin_d = op_sel[1] & x_in;

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        localparam int LW = (g == 0) ? BYTE_W : (g == 1) ? WORD_W : DATA_W;
        logic [LW-1:0] lr;

        ccg_lane #(.W(LW)) u_lane (
            .a   (opnd_dst[LW-1:0]),
            .b   (opnd_src[LW-1:0]),
            .sub (sub_d),
            .cin (cin_d),
            .r   (lr),
            .c   (lane_c[g]),
            .v   (lane_v[g]),
            .n   (lane_n[g]),
            .z   (lane_z[g])
        );

        if (LW < DATA_W) begin : g_pad
            assign lane_r[g] = {{(DATA_W-LW){1'b0}}, lr};
        end else begin : g_full
            assign lane_r[g] = lr;
        end
    end

    ccg_merge #(.DATA_W(DATA_W)) u_merge (
        .a        (opnd_dst),
        .op_sel   (op_sel),
        .size_sel (size_sel),
        .z_prev   (z_prev),
        .lane_r   (lane_r),
        .lane_c   (lane_c),
        .lane_v   (lane_v),
        .lane_n   (lane_n),
        .lane_z   (lane_z),
        .result   (result),
        .flags    (flags)
    );

endmodule

// File: tb/sim_ccgen_top.sv
module sim_ccgen_top;

    logic        clk = 1'b0;
    logic [31:0] a, b;
    logic [1:0]  op, sz;
    logic        xi, zp;
    logic [31:0] result;
    logic [4:0]  flags;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    ccgen_top #(.DATA_W(32)) u0 (
        .opnd_dst (a),
        .opnd_src (b),
        .op_sel   (op),
        .size_sel (sz),
        .x_in     (xi),
        .z_prev   (zp),
        .result   (result),
        .flags    (flags)
    );

    // reference model: 64-bit signed and unsigned range arithmetic
    function automatic logic [36:0] model(input logic [31:0] ma, mb,
                                          input logic [1:0] mop, msz,
                                          input logic mx, mzp);
        int          w;
        longint      aa, bb, sa, sb, lim, cin, sum, rs, r;
        logic        c, v, n, z;
        logic [31:0] res;
        w = (msz == 2'd0) ? 8 : (msz == 2'd1) ? 16 : 32;
        aa = longint'(ma) & ((64'sd1 <<< w) - 1);
        bb = longint'(mb) & ((64'sd1 <<< w) - 1);
        lim = 64'sd1 <<< (w - 1);
        sa = (aa >= lim) ? aa - (lim * 2) : aa;
        sb = (bb >= lim) ? bb - (lim * 2) : bb;
        cin = (mop[1] && mx) ? 1 : 0;
        if (mop[0]) begin
            sum = aa - bb - cin;
            c = (aa < bb + cin);
            rs = sa - sb - cin;
        end else begin
            sum = aa + bb + cin;
            c = (sum >= (lim * 2));
            rs = sa + sb + cin;
        end
        v = (rs >= lim) || (rs < -lim);
        r = sum & ((64'sd1 <<< w) - 1);
        n = r[w-1];
        z = (r == 0) && (mop[1] ? mzp : 1'b1);
        res = (w == 32) ? r[31:0] : ((ma & ~((32'd1 << w) - 1)) | r[31:0]);
        return {res, c, n, z, v, c};
    endfunction

    task automatic apply_chk(input string tag, input logic [31:0] ta, tb_,
                             input logic [1:0] top, tsz, input logic tx, tz);
        logic [36:0] exp;
        @(negedge clk);
        a = ta; b = tb_; op = top; sz = tsz; xi = tx; zp = tz;
        #1;
        exp = model(ta, tb_, top, tsz, tx, tz);
        checks++;
        if ({result, flags} !== exp) begin
            errors++;
            $display("FAIL %s: got res=%h flags=%b, expected res=%h flags=%b",
                     tag, result, flags, exp[36:5], exp[4:0]);
        end
    endtask

    task automatic expect_flags(input string tag, input logic [4:0] want);
        checks++;
        if (flags !== want) begin
            errors++;
            $display("FAIL %s: got flags=%b, expected %b", tag, flags, want);
        end
    endtask

    task automatic t_idle;
        @(negedge clk);
        a = '0; b = '0; op = 2'd0; sz = 2'd2; xi = 1'b0; zp = 1'b0;
        #1;
        checks++;
        if (result !== 32'h0) begin
            errors++;
            $display("FAIL R5 idle: got res=%h, expected 0", result);
        end
        expect_flags("R5 idle zero", 5'b00100);
    endtask

    task automatic t_add;
        apply_chk("R3 byte 7F+01", 32'h0000_007F, 32'h1, 2'd0, 2'd0, 1'b0, 1'b0);
        expect_flags("R3 byte 7F+01 flags", 5'b01010);
        apply_chk("R1 byte FF+01", 32'h0000_00FF, 32'h1, 2'd0, 2'd0, 1'b0, 1'b0);
        expect_flags("R7 byte FF+01 flags", 5'b10101);
        apply_chk("R1 word 8000+8000", 32'h8000, 32'h8000, 2'd0, 2'd1, 1'b0, 1'b0);
        apply_chk("R3 long max+1", 32'h7FFF_FFFF, 32'h1, 2'd0, 2'd2, 1'b0, 1'b0);
        apply_chk("R1 long FFFFFFFF+FFFFFFFF", 32'hFFFF_FFFF, 32'hFFFF_FFFF, 2'd0, 2'd2, 1'b0, 1'b0);
    endtask

    task automatic t_sub;
        apply_chk("R2 byte 00-01", 32'h0, 32'h1, 2'd1, 2'd0, 1'b0, 1'b0);
        expect_flags("R2 byte 00-01 flags", 5'b11001);
        apply_chk("R4 byte 80-01", 32'h80, 32'h1, 2'd1, 2'd0, 1'b0, 1'b0);
        expect_flags("R4 byte 80-01 flags", 5'b00010);
        apply_chk("R2 word equal", 32'h1234, 32'h1234, 2'd1, 2'd1, 1'b0, 1'b0);
        apply_chk("R4 long min-1", 32'h8000_0000, 32'h1, 2'd1, 2'd2, 1'b0, 1'b0);
        apply_chk("R4 long 7FFFFFFF-FFFFFFFF", 32'h7FFF_FFFF, 32'hFFFF_FFFF, 2'd1, 2'd2, 1'b0, 1'b0);
    endtask

    task automatic t_ext;
        apply_chk("R6 addx zero, zp=0", 32'hFF, 32'h0, 2'd2, 2'd0, 1'b1, 1'b0);
        expect_flags("R6 addx Z cleared", 5'b10001);
        apply_chk("R6 addx zero, zp=1", 32'hFF, 32'h0, 2'd2, 2'd0, 1'b1, 1'b1);
        expect_flags("R6 addx Z kept", 5'b10101);
        apply_chk("R2 subx equal x=1", 32'h55, 32'h55, 2'd3, 2'd0, 1'b1, 1'b1);
        expect_flags("R2 subx a<=b carry", 5'b11001);
        apply_chk("R1 addx word x=0", 32'hFFFF, 32'h1, 2'd2, 2'd1, 1'b0, 1'b1);
        apply_chk("R6 subx nonzero zp=1", 32'h10, 32'h3, 2'd3, 2'd2, 1'b1, 1'b1);
        apply_chk("R6 plain add ignores zp", 32'h0, 32'h0, 2'd0, 2'd2, 1'b0, 1'b0);
        expect_flags("R6 plain add Z", 5'b00100);
    endtask

    task automatic t_x_ignored;
        logic [36:0] first;
        apply_chk("R8 add x=0", 32'h1234_5678, 32'h0FED_CBA9, 2'd0, 2'd2, 1'b0, 1'b0);
        first = {result, flags};
        apply_chk("R8 add x=1", 32'h1234_5678, 32'h0FED_CBA9, 2'd0, 2'd2, 1'b1, 1'b0);
        checks++;
        if ({result, flags} !== first) begin
            errors++;
            $display("FAIL R8 add x_in effect: got %h, expected %h", {result, flags}, first);
        end
        apply_chk("R8 sub x=1", 32'h20, 32'h20, 2'd1, 2'd0, 1'b1, 1'b0);
        expect_flags("R8 sub x ignored flags", 5'b00100);
    endtask

    task automatic t_passthru;
        apply_chk("R9 byte upper", 32'hDEAD_BE10, 32'h1234_5605, 2'd1, 2'd0, 1'b0, 1'b0);
        checks++;
        if (result !== 32'hDEAD_BE0B) begin
            errors++;
            $display("FAIL R9 byte upper: got %h, expected DEADBE0B", result);
        end
        apply_chk("R9 word upper", 32'hCAFE_FFFF, 32'hFFFF_0001, 2'd0, 2'd1, 1'b0, 1'b0);
        checks++;
        if (result !== 32'hCAFE_0000) begin
            errors++;
            $display("FAIL R9 word upper: got %h, expected CAFE0000", result);
        end
    endtask

    task automatic t_size3;
        logic [36:0] want;
        apply_chk("R10 size 3 add", 32'h8000_0000, 32'h8000_0000, 2'd0, 2'd3, 1'b0, 1'b0);
        want = model(32'h8000_0000, 32'h8000_0000, 2'd0, 2'd2, 1'b0, 1'b0);
        checks++;
        if ({result, flags} !== want) begin
            errors++;
            $display("FAIL R10 size 3 vs long: got %h, expected %h", {result, flags}, want);
        end
    endtask

    task automatic t_random;
        for (int i = 0; i < 4000; i++) begin
            apply_chk("R1 R2 R3 R4 R5 random", $urandom, $urandom,
                      2'($urandom), 2'($urandom), 1'($urandom), 1'($urandom));
        end
    endtask

    initial begin
        a = '0; b = '0; op = '0; sz = '0; xi = 1'b0; zp = 1'b0;
        t_idle();
        t_add();
        t_sub();
        t_ext();
        t_x_ignored();
        t_passthru();
        t_size3();
        t_random();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule